// File: doc/BRIEF.md
# Packet Buffer Access Pointer with Read Prefetch

This block is the host-side address pointer for a packet buffer that the CPU reaches through one data port. The CPU loads a 16-bit control word through a register port that accepts byte or word writes. The word holds an 11-bit byte offset and three mode bits. The mode bits pick the area (receive or transmit), turn on auto-increment, and set the direction of later data-port accesses. Each memory request carries the area, a packet number and an offset. The packet number comes from the head of the receive completion queue or from the transmit packet number, depending on the area bit.

In read mode, a four-byte prefetch FIFO is kept full from memory, starting at the loaded offset. CPU reads of one, two or four bytes are served from the head of that FIFO. In write mode, each CPU write is split into byte entries in a small write FIFO. The FIFO drains to memory one byte per valid/ready handshake. Reading the pointer back always gives the offset the CPU last reached, never the prefetch offset. An interrupt routine can therefore save and restore the pointer safely. A status bit shows uncommitted write data. A separate error flag records a pointer load made while that status bit was set.

Top module: `pktbuf_ptr`

## Requirements
- R1: After reset, the readback word is 0, the load-error flag is 0, and no memory request is made.
- R2: A write that enables only the low byte goes into a staging register and leaves the readback unchanged. A later write that enables only the high byte loads the pointer from the high byte and the staged low byte.
- R3: A write that enables the high byte loads the pointer. The fields are area bit 15 (1 = receive), auto-increment bit 14, read mode bit 13, and offset bits 10..0. Bits 12 and 11 of the write data are ignored. Readback bit 12 is always 0 and bit 11 is the write-pending status.
- R4: With auto-increment set, each accepted data-port access advances the offset by 1, 2 or 4 for size codes 0, 1 and 2/3, modulo 2048. With auto-increment clear, the offset does not change.
- R5: Every memory request carries the area bit. Its packet number is the receive number when the area is receive, and the transmit number otherwise.
- R6: In read mode, a data-port read of N bytes returns memory bytes at offsets o..o+N-1, little-endian (byte at o in bits 7..0). The unused upper bytes read as 0.
- R7: The prefetch runs at most four bytes past the CPU offset and then stops requesting. The readback offset stays at the CPU offset while it does so.
- R8: In write mode, a data-port write of N bytes produces N memory byte writes at offsets o..o+N-1, lowest offset first, carrying data byte i for offset o+i and the area and packet number at the time of the write. Readback bit 11 is 1 while any of these writes is still pending.
- R9: Every pointer load discards any prefetched data. The next read returns bytes from the new offset.
- R10: A pointer load sets the load-error flag to the write-pending status just before the load. A load made with nothing pending clears the flag.
- R11: With auto-increment clear in read mode, repeated reads return the same bytes from the unchanged offset.
- R12: The data port does not accept an access in the cycle of a pointer load. It does not accept a read until enough prefetched bytes are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte enables of the register write (bit 1 = high byte) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Pointer readback word |
| ld_err | output | 1 | Pointer loaded while write data was pending |
| tx_pnum | input | PN_W | Transmit packet number |
| rx_pnum | input | PN_W | Packet number at the head of the receive queue |
| dp_valid | input | 1 | Data-port access request |
| dp_size | input | 2 | Access size: 0 byte, 1 word, 2/3 doubleword |
| dp_wdata | input | 32 | Data-port write data |
| dp_ready | output | 1 | Data-port access accepted this cycle |
| dp_rdata | output | 32 | Data-port read data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | Request is a write |
| mem_rx | output | 1 | Request targets the receive area |
| mem_pnum | output | PN_W | Packet number of the request |
| mem_off | output | 11 | Byte offset of the request |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the handshake cycle |

## Verification
Reads are swept over all three sizes, both areas and start offsets at zero, mid-range and just below the 2047 wrap. This separates wrong increments, wrong byte order, a wrong packet-number source and a missed wrap. Memory contents are a function of area, packet number and offset, so a wrong source shows up as wrong data. Writes are swept the same way with memory stalls, which exposes wrong byte splitting and a wrong pending status. Directed sequences cover split loads, ignored bits, reloads during prefetch, loads with write data pending, and non-incrementing reads.

// File: rtl/pbp_pkg.sv
// Shared constants, field positions and the access-size decode for the
// packet buffer pointer. Assumes a fixed 16-bit control word layout.
package pbp_pkg;
    localparam int OFF_W  = 11;   // byte offset width inside a packet
    localparam int MAXB   = 4;    // widest data-port access in bytes
    localparam int B_RCV  = 15;   // area select: 1 = receive
    localparam int B_AINC = 14;   // auto-increment enable
    localparam int B_RD   = 13;   // read mode

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWALT = 2'd3
    } dp_size_e;

    // Number of bytes moved by one data-port access of the given size.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/pbp_lane_fifo.sv
// Small FIFO that can push and pop several entries per cycle.
// Assumes: DEPTH is a power of two >= 2, the caller never pushes past
// free space or pops past the count, and flush beats push and pop.
module pbp_lane_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int LANES = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NW   = $clog2(LANES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic [NW-1:0]             push_n,
    input  logic [LANES-1:0][W-1:0]   push_data,
    input  logic [NW-1:0]             pop_n,
    output logic [LANES-1:0][W-1:0]   head,
    output logic [CW-1:0]             count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    // Storage write; data needs no reset because the count guards it.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (NW'(i) < push_n)
                mem[AW'(wr_ptr + AW'(i))] <= push_data[i];
        end
    end

    // Expose the oldest LANES entries in order.
    for (genvar g = 0; g < LANES; g++) begin : g_head
        assign head[g] = mem[AW'(rd_ptr + AW'(g))];
    end
endmodule

// File: rtl/pbp_ptr_reg.sv
// Control/pointer register: low-byte staging, load, auto-increment and
// the load-error flag. Assumes the caller only advances when an access
// is accepted, which never happens in a load cycle.
module pbp_ptr_reg
    import pbp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_be,
    input  logic [15:0]      reg_wdata,
    input  logic             wr_pending,
    input  logic             adv_en,
    input  logic [2:0]       adv_by,
    output logic             commit,
    output logic             rcv,
    output logic             ainc,
    output logic             rd_mode,
    output logic [OFF_W-1:0] cpu_off,
    output logic             ld_err
);
    logic [7:0] lo_stage;
    logic       unused_bits;

    assign commit      = reg_wr && reg_be[1];
    assign unused_bits = ^reg_wdata[12:11];

    // Hold a lone low-byte write until the high byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_stage <= '0;
        else if (reg_wr && reg_be == 2'b01)
            lo_stage <= reg_wdata[7:0];
    end

    // Live pointer: load on high-byte write, otherwise advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcv     <= 1'b0;
            ainc    <= 1'b0;
            rd_mode <= 1'b0;
            cpu_off <= '0;
            ld_err  <= 1'b0;
        end else if (commit) begin
            rcv     <= reg_wdata[B_RCV];
            ainc    <= reg_wdata[B_AINC];
            rd_mode <= reg_wdata[B_RD];
            cpu_off <= {reg_wdata[OFF_W-1:8],
                        reg_be[0] ? reg_wdata[7:0] : lo_stage};
            ld_err  <= wr_pending;
        end else if (adv_en) begin
            cpu_off <= cpu_off + OFF_W'(adv_by);
        end
    end
endmodule

// File: rtl/pktbuf_ptr.sv
// Packet buffer access pointer. Forms byte requests to packet memory from
// the pointer register, prefetches read bytes into a short FIFO and
// buffers write bytes until memory takes them. Memory read data must be
// valid in the handshake cycle. Assumes RDEPTH >= 4 and WDEPTH >= 4.
module pktbuf_ptr #(
    parameter int PN_W   = 6,
    parameter int RDEPTH = 4,
    parameter int WDEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [1:0]              reg_be,
    input  logic [15:0]             reg_wdata,
    output logic [15:0]             reg_rdata,
    output logic                    ld_err,
    input  logic [PN_W-1:0]         tx_pnum,
    input  logic [PN_W-1:0]         rx_pnum,
    input  logic                    dp_valid,
    input  logic [1:0]              dp_size,
    input  logic [31:0]             dp_wdata,
    output logic                    dp_ready,
    output logic [31:0]             dp_rdata,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic                    mem_we,
    output logic                    mem_rx,
    output logic [PN_W-1:0]         mem_pnum,
    output logic [pbp_pkg::OFF_W-1:0] mem_off,
    output logic [7:0]              mem_wdata,
    input  logic [7:0]              mem_rdata
);
    import pbp_pkg::*;

    localparam int EW  = 1 + PN_W + OFF_W + 8;
    localparam int RCW = $clog2(RDEPTH + 1);
    localparam int WCW = $clog2(WDEPTH + 1);
    localparam int NW  = $clog2(MAXB + 1);

    logic             commit, rcv, ainc, rd_mode, wr_pending, fire;
    logic [OFF_W-1:0] cpu_off;
    logic [2:0]       nb;
    logic [PN_W-1:0]  pnum_sel;
    logic             rd_ready, wr_ready, mem_fire, rflush;
    logic [RCW-1:0]   rcnt;
    logic [WCW-1:0]   wcnt;
    logic [NW-1:0]    rpush_n, rpop_n, wpush_n, wpop_n;
    logic [MAXB-1:0][7:0]    rpush_data, rhead;
    logic [MAXB-1:0][EW-1:0] wpush_data, whead;
    logic             unused_whead;

    pbp_ptr_reg u_reg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .wr_pending(wr_pending),
        .adv_en(fire && ainc), .adv_by(nb), .commit(commit), .rcv(rcv),
        .ainc(ainc), .rd_mode(rd_mode), .cpu_off(cpu_off), .ld_err(ld_err)
    );

    // Access sizing, area selection and readback.
    assign nb         = size_bytes(dp_size);
    assign pnum_sel   = rcv ? rx_pnum : tx_pnum;
    assign wr_pending = (wcnt != '0);
    assign reg_rdata  = {rcv, ainc, rd_mode, 1'b0, wr_pending, cpu_off};

    // Data-port acceptance: never during a load, reads need enough bytes.
    assign rd_ready = !wr_pending && (int'(rcnt) >= int'(nb));
    assign wr_ready = (WDEPTH - int'(wcnt)) >= int'(nb);
    assign dp_ready = !commit && (rd_mode ? rd_ready : wr_ready);
    assign fire     = dp_valid && dp_ready;

    // Memory request: drain writes first, otherwise top up the prefetch.
    assign mem_valid = wr_pending || (rd_mode && int'(rcnt) < RDEPTH);
    assign mem_we    = wr_pending;
    assign mem_rx    = wr_pending ? whead[0][EW-1] : rcv;
    assign mem_pnum  = wr_pending ? whead[0][EW-2 -: PN_W] : pnum_sel;
    assign mem_off   = wr_pending ? whead[0][OFF_W+7:8]
                                  : cpu_off + OFF_W'(rcnt);
    assign mem_wdata = whead[0][7:0];
    assign mem_fire  = mem_valid && mem_ready;

    // Prefetch FIFO control: flush on load and after a non-advancing read.
    assign rpush_n    = (mem_fire && !mem_we) ? NW'(1) : '0;
    assign rpop_n     = (fire && rd_mode) ? NW'(nb) : '0;
    assign rflush     = commit || (fire && rd_mode && !ainc);
    assign rpush_data = {MAXB{mem_rdata}};

    // Write FIFO control: one entry per byte of a data-port write.
    assign wpush_n = (fire && !rd_mode) ? NW'(nb) : '0;
    assign wpop_n  = (mem_fire && mem_we) ? NW'(1) : '0;
    assign unused_whead = ^whead[MAXB-1:1];

    for (genvar g = 0; g < MAXB; g++) begin : g_lane
        assign wpush_data[g] = {rcv, pnum_sel, cpu_off + OFF_W'(g),
                                dp_wdata[8*g +: 8]};
        assign dp_rdata[8*g +: 8] = (3'(g) < nb) ? rhead[g] : 8'h00;
    end

    pbp_lane_fifo #(.W(8), .DEPTH(RDEPTH), .LANES(MAXB)) u_rfifo (
        .clk(clk), .rst_n(rst_n), .flush(rflush), .push_n(rpush_n),
        .push_data(rpush_data), .pop_n(rpop_n), .head(rhead), .count(rcnt)
    );

    pbp_lane_fifo #(.W(EW), .DEPTH(WDEPTH), .LANES(MAXB)) u_wfifo (
        .clk(clk), .rst_n(rst_n), .flush(1'b0), .push_n(wpush_n),
        .push_data(wpush_data), .pop_n(wpop_n), .head(whead), .count(wcnt)
    );
endmodule

// File: rtl/pktbuf_ptr_chk.sv
// Port-level properties of the packet buffer pointer, bound to every
// instance. Assumes synchronous active-low reset.
module pktbuf_ptr_chk #(
    parameter int PN_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [1:0]      reg_be,
    input logic [15:0]     reg_rdata,
    input logic            ld_err,
    input logic [PN_W-1:0] tx_pnum,
    input logic [PN_W-1:0] rx_pnum,
    input logic            dp_valid,
    input logic            dp_ready,
    input logic [1:0]      dp_size,
    input logic            mem_valid,
    input logic            mem_we,
    input logic            mem_rx,
    input logic [PN_W-1:0] mem_pnum
);
    import pbp_pkg::*;

    // R2: a lone low-byte write leaves the live pointer alone.
    p_lowstage_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_be == 2'b01 && !(dp_valid && dp_ready)) |=>
        (reg_rdata[15:13] == $past(reg_rdata[15:13]) &&
         reg_rdata[10:0] == $past(reg_rdata[10:0])));

    // R4: accepted access with auto-increment advances by the size.
    p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && dp_ready && reg_rdata[B_AINC]) |=>
        (reg_rdata[10:0] == $past(reg_rdata[10:0]) +
                            11'(size_bytes($past(dp_size)))));

    // R11: accepted access without auto-increment holds the offset.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && dp_ready && !reg_rdata[B_AINC]) |=>
        $stable(reg_rdata[10:0]));

    // R5: prefetch requests use the selected area and packet number.
    p_area_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we) |->
        (mem_rx == reg_rdata[B_RCV] &&
         mem_pnum == (reg_rdata[B_RCV] ? rx_pnum : tx_pnum)));

    // R10: the error flag captures the pending status at the load.
    p_lderr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_be[1]) |=> (ld_err == $past(reg_rdata[11])));

    // R8: a memory write is only issued while write data is pending.
    p_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> reg_rdata[11]);

    // R12: no access is accepted in a pointer load cycle.
    p_noload_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_be[1]) |-> !dp_ready);
endmodule

bind pktbuf_ptr pktbuf_ptr_chk #(.PN_W(PN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
    .reg_rdata(reg_rdata), .ld_err(ld_err), .tx_pnum(tx_pnum),
    .rx_pnum(rx_pnum), .dp_valid(dp_valid), .dp_ready(dp_ready),
    .dp_size(dp_size), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_rx(mem_rx), .mem_pnum(mem_pnum)
);

// File: tb/pktbuf_ptr_bench.sv
// Self-checking bench: memory is a pure function of area, packet number
// and offset, so every read value and write record is computed here.
module pktbuf_ptr_bench;
    localparam int PN_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ld_err;
    logic [PN_W-1:0] tx_pnum = 6'd5;
    logic [PN_W-1:0] rx_pnum = 6'd42;
    logic        dp_valid = 1'b0;
    logic [1:0]  dp_size = 2'd0;
    logic [31:0] dp_wdata = '0;
    logic        dp_ready;
    logic [31:0] dp_rdata;
    logic        mem_valid, mem_ready, mem_we, mem_rx;
    logic [PN_W-1:0] mem_pnum;
    logic [10:0] mem_off;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_rdy_en = 1'b1;
    int          cyc = 0;
    int          checks = 0;
    int          failures = 0;

    logic        log_rx   [256];
    logic [5:0]  log_pn   [256];
    logic [10:0] log_off  [256];
    logic [7:0]  log_dat  [256];
    int          wn = 0;

    always #10 clk = ~clk;

    pktbuf_ptr u_pktbuf_ptr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ld_err(ld_err),
        .tx_pnum(tx_pnum), .rx_pnum(rx_pnum), .dp_valid(dp_valid),
        .dp_size(dp_size), .dp_wdata(dp_wdata), .dp_ready(dp_ready),
        .dp_rdata(dp_rdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_we(mem_we), .mem_rx(mem_rx), .mem_pnum(mem_pnum),
        .mem_off(mem_off), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] fmem(logic a, logic [5:0] p, logic [10:0] o);
        return (o[7:0] * 8'd7) ^ {o[10:8], 5'd0} ^ {2'b00, p} ^ (a ? 8'hA5 : 8'h00);
    endfunction

    function automatic int nbf(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [15:0] ctl(logic r, logic ai, logic rd, logic [10:0] o);
        return {r, ai, rd, 2'b00, o};
    endfunction

    function automatic logic [31:0] wpat(int k, logic [10:0] st);
        return 32'hA0B1C2D3 ^ (32'(k) * 32'h01010101) ^ {21'd0, st};
    endfunction

    assign mem_ready = mem_rdy_en && (cyc % 3 != 2);
    assign mem_rdata = fmem(mem_rx, mem_pnum, mem_off);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_valid && mem_ready && mem_we) begin
            log_rx[wn[7:0]]  <= mem_rx;
            log_pn[wn[7:0]]  <= mem_pnum;
            log_off[wn[7:0]] <= mem_off;
            log_dat[wn[7:0]] <= mem_wdata;
            wn <= wn + 1;
        end
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 2'b00;
    endtask

    task automatic dp_do(input logic [1:0] sz, input logic [31:0] wd,
                         output logic [31:0] rdv);
        rdv = '0;
        @(negedge clk);
        dp_valid = 1'b1; dp_size = sz; dp_wdata = wd;
        for (int k = 0; k < 2000; k++) begin
            #1;
            if (dp_ready) begin
                rdv = dp_rdata;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        dp_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (!reg_rdata[11]) break;
        end
    endtask

    initial begin
        logic [31:0] rv, rv2, ex;
        logic [10:0] o;
        logic [5:0]  pn;
        int          base, nb;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 readback", {16'd0, reg_rdata}, 32'd0);
        chk("R1 ld_err", {31'd0, ld_err}, 32'd0);
        chk("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R6 R7: read sweep over area, size and start offset
        for (int a = 0; a < 2; a++) begin
            for (int s = 0; s < 3; s++) begin
                for (int si = 0; si < 3; si++) begin
                    o  = (si == 0) ? 11'd0 : (si == 1) ? 11'd13 : 11'd2045;
                    pn = a[0] ? rx_pnum : tx_pnum;
                    nb = nbf(2'(s));
                    reg_write(2'b11, ctl(a[0], 1'b1, 1'b1, o));
                    chk("R3 load fields", {16'd0, reg_rdata},
                        {16'd0, ctl(a[0], 1'b1, 1'b1, o)});
                    repeat (10) @(negedge clk);
                    chk("R7 cpu offset held", {21'd0, reg_rdata[10:0]}, {21'd0, o});
                    chk("R7 prefetch stops", {31'd0, mem_valid}, 32'd0);
                    for (int k = 0; k < 5; k++) begin
                        dp_do(2'(s), 32'd0, rv);
                        ex = '0;
                        for (int i = 0; i < nb; i++)
                            ex[8*i +: 8] = fmem(a[0], pn, o + 11'(i));
                        chk("R6 R5 read data", rv, ex);
                        o = o + 11'(nb);
                        chk("R4 advance", {21'd0, reg_rdata[10:0]}, {21'd0, o});
                    end
                end
            end
        end

        // R2: split load through the low-byte staging register
        reg_write(2'b11, ctl(1'b0, 1'b0, 1'b0, 11'h055));
        reg_write(2'b01, 16'h0077);
        chk("R2 low byte staged only", {16'd0, reg_rdata}, 32'h0000_0055);
        reg_write(2'b10, 16'hC200);
        chk("R2 split load", {16'd0, reg_rdata}, 32'h0000_C277);
        // R3: bits 12 and 11 of the write are ignored
        reg_write(2'b11, 16'hDA34);
        chk("R3 ignored bits", {16'd0, reg_rdata}, 32'h0000_C234);

        // R8: write sweep with stalled then running memory
        for (int s = 0; s < 3; s++) begin
            for (int si = 0; si < 2; si++) begin
                o  = (si == 0) ? 11'd4 : 11'd2046;
                nb = nbf(2'(s));
                pn = si[0] ? rx_pnum : tx_pnum;
                base = wn;
                reg_write(2'b11, ctl(si[0], 1'b1, 1'b0, o));
                mem_rdy_en = 1'b0;
                dp_do(2'(s), wpat(0, o), rv);
                chk("R8 pending set", {31'd0, reg_rdata[11]}, 32'd1);
                mem_rdy_en = 1'b1;
                for (int k = 1; k < 3; k++) dp_do(2'(s), wpat(k, o), rv);
                wait_idle();
                chk("R8 pending clear", {31'd0, reg_rdata[11]}, 32'd0);
                chk("R8 write count", 32'(wn - base), 32'(3 * nb));
                chk("R4 write advance", {21'd0, reg_rdata[10:0]},
                    {21'd0, o + 11'(3 * nb)});
                for (int k = 0; k < 3; k++) begin
                    for (int i = 0; i < nb; i++) begin
                        int j;
                        j = base + k * nb + i;
                        chk("R8 write record",
                            {log_rx[j[7:0]], 6'd0, log_pn[j[7:0]], log_off[j[7:0]], log_dat[j[7:0]]},
                            {si[0], 6'd0, pn, o + 11'(k * nb + i), wpat(k, o)[8*i +: 8]});
                    end
                end
            end
        end

        // R10: load with pending write data sets the flag
        reg_write(2'b11, ctl(1'b0, 1'b1, 1'b0, 11'h100));
        mem_rdy_en = 1'b0;
        base = wn;
        dp_do(2'd0, 32'h0000_003C, rv);
        reg_write(2'b11, ctl(1'b0, 1'b1, 1'b0, 11'h200));
        chk("R10 flag set", {31'd0, ld_err}, 32'd1);
        mem_rdy_en = 1'b1;
        wait_idle();
        chk("R8 write survives load", {log_off[base[7:0]], log_dat[base[7:0]]},
            {11'h100, 8'h3C});
        reg_write(2'b11, ctl(1'b0, 1'b1, 1'b0, 11'h300));
        chk("R10 flag clear", {31'd0, ld_err}, 32'd0);

        // R9: reload while prefetch holds data
        reg_write(2'b11, ctl(1'b0, 1'b1, 1'b1, 11'd100));
        dp_do(2'd0, 32'd0, rv);
        repeat (6) @(negedge clk);
        reg_write(2'b11, ctl(1'b0, 1'b1, 1'b1, 11'd500));
        dp_do(2'd2, 32'd0, rv);
        ex = {fmem(0, tx_pnum, 11'd503), fmem(0, tx_pnum, 11'd502),
              fmem(0, tx_pnum, 11'd501), fmem(0, tx_pnum, 11'd500)};
        chk("R9 flushed reload", rv, ex);

        // R11: non-advancing reads repeat the same bytes
        reg_write(2'b11, ctl(1'b1, 1'b0, 1'b1, 11'h040));
        dp_do(2'd2, 32'd0, rv);
        dp_do(2'd2, 32'd0, rv2);
        ex = {fmem(1, rx_pnum, 11'h043), fmem(1, rx_pnum, 11'h042),
              fmem(1, rx_pnum, 11'h041), fmem(1, rx_pnum, 11'h040)};
        chk("R11 first read", rv, ex);
        chk("R11 repeat read", rv2, ex);
        dp_do(2'd1, 32'd0, rv);
        chk("R11 word read", rv, {16'd0, ex[15:0]});
        chk("R11 offset held", {21'd0, reg_rdata[10:0]}, 32'h040);

        // R12: no acceptance in a load cycle, reads wait for bytes
        @(negedge clk);
        reg_wr = 1'b1; reg_be = 2'b11; reg_wdata = ctl(1'b0, 1'b1, 1'b1, 11'd8);
        dp_valid = 1'b1; dp_size = 2'd0;
        #1;
        chk("R12 blocked in load cycle", {31'd0, dp_ready}, 32'd0);
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 2'b00; dp_size = 2'd2;
        #1;
        chk("R12 empty prefetch blocks", {31'd0, dp_ready}, 32'd0);
        @(negedge clk);
        dp_valid = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule